// File: doc/BRIEF.md
# Prescaled Timeout Timer With Halt

This block is an interval timer for a small sensor-processing controller. Software programs a prescale code and a 12-bit timeout into a configuration register, then writes the enable bit of a control register. The block divides the oscillator clock by the selected factor, counts the prescaled ticks and, once the timeout is reached, raises a done flag and drops the enable bit by itself.

The prescale factor is a power of two from 1 to 128, optionally multiplied by three, so it ranges from 1 to 384. If the halt-enable bit is set, a CPU-halt output stays high for the whole interval. This lets firmware stall for a fixed number of oscillator cycles without polling.

Both registers sit on a plain single-cycle register port. A write takes effect on the clock edge on which `wr_en` is high. Reads are combinational, selected by `rd_sel`. The port has no back-pressure: every write is accepted in its own cycle.

Top module: `pto_timer`

## Requirements
- R1: After the synchronous active-high reset, both registers read 0x0000 and `cpu_halt` is low.
- R2: Configuration register (select 0): bits 15:12 hold the prescale code and bits 11:0 hold the timeout. Any written value reads back unchanged.
- R3: Control register (select 1) reads as {done at bit 15, enable at bit 14, zeros at bits 13:1, halt-enable at bit 0}. Bits 13:1 always read zero, and every control write loads halt-enable from bit 0.
- R4: A control write with bit 14 = 1 sets enable and clears done on that edge.
- R5: After a start, done sets and enable clears max(T,1)×P clock edges after the write edge, where T is the timeout and P is the prescale factor.
- R6: The prescale factor is P = (code[0] ? 3 : 1) × 2^code[3:1].
- R7: A timeout of zero completes after exactly P cycles, which is the first prescaled tick.
- R8: `cpu_halt` is high exactly while enable and halt-enable are both 1.
- R9: A control write with bit 14 = 0 during a run stops the timer at once, and done is not set.
- R10: A control write with bit 14 = 1 during a run restarts the interval from zero.
- R11: Once set, done holds until the next start. Writes to bit 15 have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 configuration, 1 control |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read target: 0 configuration, 1 control |
| rd_data | output | 16 | Read data for the selected register |
| cpu_halt | output | 1 | Halt request to the processor |

## Verification
The bench sweeps every prescale code against timeouts 0 to 3, a large prescale with a mid-size timeout, and the maximum timeout. It measures the exact cycle on which done appears. A divider off by one, a wrong ×3 decode, or a zero timeout that waited a full 4096 ticks would each land on the wrong cycle. It also stops a run partway and restarts another. A design that set done on a stop, or that kept its old count across a restart, would finish early or report done falsely. Halt is sampled on every cycle of every run, so a halt output that lagged enable or ignored halt-enable would be caught.

// File: rtl/pto_pkg.sv
package pto_pkg;
  localparam int REG_W    = 16;
  localparam int TO_W     = 12;
  localparam int PS_W     = REG_W - TO_W;
  localparam int PRE_W    = 9;
  localparam int DONE_BIT = 15;
  localparam int RUN_BIT  = 14;
  localparam int HALT_BIT = 0;

  function automatic logic [PRE_W-1:0] prescale_factor(input logic [PS_W-1:0] code);
    logic [PRE_W-1:0] base;
    base = code[0] ? PRE_W'(3) : PRE_W'(1);
    return base << code[PS_W-1:1];
  endfunction
endpackage

// File: rtl/pto_prescaler.sv
module pto_prescaler
  import pto_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            run,
  input  logic [PS_W-1:0] code,
  output logic            tick
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] last;

  assign last = prescale_factor(code) - PRE_W'(1);
  assign tick = run && (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt <= '0;
    else if (run)      cnt <= tick ? '0 : cnt + PRE_W'(1);
  end
endmodule

// File: rtl/pto_tick_counter.sv
module pto_tick_counter
  import pto_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            tick,
  input  logic [TO_W-1:0] limit,
  output logic            expire
);
  logic [TO_W:0] cnt;
  logic [TO_W:0] cnt_nxt;

  assign cnt_nxt = cnt + (TO_W+1)'(1);
  assign expire  = tick && (cnt_nxt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (tick)    cnt <= cnt_nxt;
  end
endmodule

// File: rtl/pto_timer.sv
module pto_timer
  import pto_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic             cpu_halt
);
  logic [PS_W-1:0] ps_q;
  logic [TO_W-1:0] to_q;
  logic            run_q;
  logic            done_q;
  logic            halt_en_q;
  logic            ctrl_wr;
  logic            start;
  logic            tick;
  logic            expire;

  assign ctrl_wr = wr_en && wr_sel;
  assign start   = ctrl_wr && wr_data[RUN_BIT];

  pto_prescaler u_pre (
    .clk(clk), .rst(rst), .clear(start), .run(run_q),
    .code(ps_q), .tick(tick)
  );

  pto_tick_counter u_cnt (
    .clk(clk), .rst(rst), .clear(start), .tick(tick),
    .limit(to_q), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q      <= '0;
      to_q      <= '0;
      run_q     <= 1'b0;
      done_q    <= 1'b0;
      halt_en_q <= 1'b0;
    end else begin
      if (wr_en && !wr_sel) begin
        ps_q <= wr_data[REG_W-1:TO_W];
        to_q <= wr_data[TO_W-1:0];
      end
      if (ctrl_wr) begin
        halt_en_q <= wr_data[HALT_BIT];
        run_q     <= wr_data[RUN_BIT];
        if (wr_data[RUN_BIT]) done_q <= 1'b0;
      end else if (expire) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    if (rd_sel) begin
      rd_data           = '0;
      rd_data[DONE_BIT] = done_q;
      rd_data[RUN_BIT]  = run_q;
      rd_data[HALT_BIT] = halt_en_q;
    end else begin
      rd_data = {ps_q, to_q};
    end
  end

  assign cpu_halt = run_q && halt_en_q;
endmodule

// File: rtl/pto_timer_chk.sv
module pto_timer_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [15:0] wr_data,
  input logic        run_q,
  input logic        done_q,
  input logic        cpu_halt
);
  // R4
  start_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel && wr_data[14]) |=> (run_q && !done_q));
  // R9
  stop_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel && !wr_data[14]) |=> (!run_q && done_q == $past(done_q)));
  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && !(wr_en && wr_sel && wr_data[14])) |=> done_q);
  // R5
  done_from_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> ($past(run_q) && !run_q));
  // R8
  halt_not_done_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_halt |-> (!done_q && run_q));
endmodule

bind pto_timer pto_timer_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .run_q(run_q), .done_q(done_q), .cpu_halt(cpu_halt)
);

// File: tb/pto_timer_tb.sv
module pto_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [15:0] rd_data;
  logic        cpu_halt;
  int errors = 0;
  int checks = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  pto_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .cpu_halt(cpu_halt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int factor(input int code);
    return ((code & 1) ? 3 : 1) << (code >> 1);
  endfunction

  task automatic run_case(input int code, input int t, input bit he, input string req);
    int exp, got, n;
    bit bad;
    exp = ((t == 0) ? 1 : t) * factor(code);
    wr(1'b0, 16'((code << 12) | t));
    wr(1'b1, {2'b01, 13'd0, he});
    rd_sel = 1'b1; n = 0; got = -1; bad = 0;
    while (n < exp + 5 && got < 0) begin
      @(negedge clk); n++;
      if (rd_data[15]) got = n;
      else if (cpu_halt != he || !rd_data[14]) bad = 1;
    end
    chk(got == exp, req, got, exp);
    chk(!bad, "R8 halt during run", int'(bad), 0);
    chk(!rd_data[14] && !cpu_halt, "R5 enable cleared", int'(rd_data[14]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd_sel = 1'b0; #1;
    chk(rd_data == 16'h0, "R1 cfg reset", rd_data, 0);
    rd_sel = 1'b1; #1;
    chk(rd_data == 16'h0 && !cpu_halt, "R1 ctrl reset", rd_data, 0);

    wr(1'b0, 16'hA5C3); rd_sel = 1'b0; #1;
    chk(rd_data == 16'hA5C3, "R2 cfg readback", rd_data, 16'hA5C3);
    wr(1'b1, 16'h3FFF); rd_sel = 1'b1; #1;
    chk(rd_data == 16'h0001, "R3 reserved bits zero", rd_data, 1);
    wr(1'b1, 16'h0000); #1;
    chk(rd_data == 16'h0000, "R3 halt enable clear", rd_data, 0);

    for (int c = 0; c < 16; c++)
      for (int t = 0; t < 4; t++)
        run_case(c, t, 1'((c + t) & 1), (t == 0) ? "R7 zero timeout" : "R6 R5 interval");
    run_case(15, 20, 1'b1, "R5 R6 large prescale");
    run_case(0, 4095, 1'b0, "R5 max timeout");

    // R11: done holds across writes that do not start
    wr(1'b1, 16'h8000); rd_sel = 1'b1; #1;
    chk(rd_data[15] == 1'b1, "R11 done holds", rd_data[15], 1);

    // R4: start clears done at once
    wr(1'b0, 16'h0064);
    wr(1'b1, 16'h4001); #1;
    chk(rd_data == 16'h4001 && cpu_halt, "R4 start clears done", rd_data, 16'h4001);

    // R9: stop mid-run
    repeat (10) @(negedge clk);
    wr(1'b1, 16'h0001); #1;
    chk(rd_data == 16'h0001 && !cpu_halt, "R9 stop", rd_data, 1);
    repeat (200) @(negedge clk);
    chk(rd_data[15] == 1'b0, "R9 no done after stop", rd_data[15], 0);

    // R10: restart mid-run, code 2 -> P=2, T=50 -> 100 cycles
    wr(1'b0, 16'h2032);
    wr(1'b1, 16'h4000);
    repeat (40) @(negedge clk);
    begin
      int n, got;
      wr(1'b1, 16'h4000);
      n = 0; got = -1;
      while (n < 120 && got < 0) begin
        @(negedge clk); n++;
        if (rd_data[15]) got = n;
      end
      chk(got == 100, "R10 restart", got, 100);
    end

    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule